// File: doc/BRIEF.md
# Layered Neuron Forward-Pass Engine

This block evaluates an already trained feedforward perceptron network, one neuron per pass, using three external memories. A read-only store supplies the synapse weights and biases, a scratch RAM holds the activations of every layer, and a read-only table holds the squashing curve. The environment places the network inputs in the first RAM words and pulses `start`. The engine then works through the hidden and output layers in order, and `done` reports when the last output has been stored.

For each neuron the engine reads one previous-layer activation and one weight per clock and accumulates their product. It then adds the bias, aligned to the product scale. It rounds the wide sum to a table index, clamps the index to the table's range and fetches the curve value. The fetched value is written into the neuron's own RAM word, where the next layer reads it. Layer count and layer sizes are parameters.

Top module: `mlp_forward_engine`

## Requirements
- R1: While reset is held and while idle, `done` is low and `act_we` is low.
- R2: The input-layer words (RAM addresses below the first layer size) are never written, so their values pass unchanged to the first hidden layer as identity outputs.
- R3: Layers are evaluated in increasing order and neurons in increasing order within a layer. The activation of neuron n of layer l is written to RAM address (sum of the sizes of layers 0..l-1) + n. During the multiply steps, word (base of layer l-1) + k is read for step k.
- R4: Activations are unsigned with 8 fraction bits (256 = 1.0). Weights and biases are signed 12-bit values with 8 fraction bits. The written value is the table entry at the index derived from acc = sum(act*w) + bias*256.
- R5: The weight store holds, for each non-input neuron in evaluation order, its weights in ascending source order followed by its bias, packed from address 0. During the multiply steps and the following bias step, the weight address steps by one per clock.
- R6: The index is floor((acc + 2048) / 4096) + 128, so an exact half step rounds upward (acc = 2048 gives 129, acc = -2048 gives 128, acc = 1792 gives 128).
- R7: An index below 0 becomes 0, and an index above 255 becomes 255.
- R8: A neuron whose previous layer has N neurons takes N + 4 clocks, and its write strobe is high in the last of them. Counting starts with the first clock after `start` is sampled.
- R9: `done` is high for exactly one clock, in the clock right after the last output neuron's write.
- R10: A `start` pulse arriving while an evaluation is in progress is ignored: the write schedule is unchanged and only one `done` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (sampled when idle) |
| done | output | 1 | One-clock completion pulse |
| wb_addr | output | ROM_AW | Weight/bias store address |
| wb_rdata | input | WT_W | Weight/bias word, one clock after address |
| act_addr | output | RAM_AW | Activation RAM address (read or write) |
| act_we | output | 1 | Activation RAM write strobe |
| act_wdata | output | ACT_W | Activation written back |
| act_rdata | input | ACT_W | Activation read data, one clock after address |
| sig_addr | output | SIG_AW | Squashing-table index |
| sig_rdata | input | ACT_W | Squashing-table value, one clock after index |

## Verification
The hardest conditions to reach from the ports are an accumulated sum that lands exactly on a rounding half step, and sums large enough to overrun the table in either direction. In normal use both are buried under a nonlinear curve. The bench therefore swaps in a ramp table whose entry equals its index, so the written word exposes the index itself. It loads hand-picked weights that put the sum at exactly +2048, exactly -2048, just below a half step, and far past both ends. A second `start` is also driven in the middle of a run and on the final write clock, where the engine has not yet returned to idle.

// File: rtl/mlp_fwd_pkg.sv
package mlp_fwd_pkg;

    localparam int SZ_W       = 8;
    localparam int MAX_LAYERS = 8;

    typedef logic [SZ_W*MAX_LAYERS-1:0] layer_vec_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MAC,
        PH_BIAS,
        PH_ADD,
        PH_LUT,
        PH_WR
    } phase_t;

    function automatic int size_of(layer_vec_t v, int l);
        return int'(v[l*SZ_W +: SZ_W]);
    endfunction

    function automatic int base_of(layer_vec_t v, int l);
        int s = 0;
        for (int j = 0; j < MAX_LAYERS; j++)
            if (j < l) s += size_of(v, j);
        return s;
    endfunction

    function automatic int rom_words(layer_vec_t v, int n);
        int s = 0;
        for (int j = 1; j < MAX_LAYERS; j++)
            if (j < n) s += size_of(v, j) * (size_of(v, j - 1) + 1);
        return s;
    endfunction

    function automatic int clog2_min1(int x);
        return (x <= 2) ? 1 : $clog2(x);
    endfunction

endpackage

// File: rtl/mlp_layer_map.sv
module mlp_layer_map
    import mlp_fwd_pkg::*;
#(
    parameter int         NUM_LAYERS  = 3,
    parameter layer_vec_t LAYER_SIZES = 64'h020302,
    parameter int         LYR_W       = 2,
    parameter int         RAM_AW      = 3
) (
    input  logic [LYR_W-1:0]  layer_idx,
    output logic [SZ_W-1:0]   cur_size,
    output logic [SZ_W-1:0]   prev_size,
    output logic [RAM_AW-1:0] cur_base,
    output logic [RAM_AW-1:0] prev_base,
    output logic              is_last
);

    logic [SZ_W-1:0]   sz_tbl   [NUM_LAYERS];
    logic [RAM_AW-1:0] base_tbl [NUM_LAYERS];

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_tbl
        localparam int SZ_G   = size_of(LAYER_SIZES, g);
        localparam int BASE_G = base_of(LAYER_SIZES, g);
        assign sz_tbl[g]   = SZ_W'(SZ_G);
        assign base_tbl[g] = RAM_AW'(BASE_G);
    end

    always_comb begin
        cur_size  = '0;
        prev_size = '0;
        cur_base  = '0;
        prev_base = '0;
        for (int g = 0; g < NUM_LAYERS; g++) begin
            if (int'(layer_idx) == g) begin
                cur_size = sz_tbl[g];
                cur_base = base_tbl[g];
            end
            if (int'(layer_idx) == g + 1) begin
                prev_size = sz_tbl[g];
                prev_base = base_tbl[g];
            end
        end
        is_last = (int'(layer_idx) == NUM_LAYERS - 1);
    end

endmodule

// File: rtl/mlp_mac_unit.sv
module mlp_mac_unit #(
    parameter int ACT_W = 9,
    parameter int WT_W  = 12,
    parameter int ACC_W = 32
) (
    input  logic [ACT_W-1:0]        act,
    input  logic signed [WT_W-1:0]  wt,
    output logic signed [ACC_W-1:0] prod
);

    localparam int PW = ACT_W + WT_W + 1;

    logic signed [ACT_W:0]  act_s;
    logic signed [PW-1:0]   act_x;
    logic signed [PW-1:0]   wt_x;
    logic signed [PW-1:0]   full;

    assign act_s = {1'b0, act};
    assign act_x = PW'(act_s);
    assign wt_x  = PW'(wt);
    assign full  = act_x * wt_x;
    assign prod  = ACC_W'(full);

endmodule

// File: rtl/mlp_sig_index.sv
module mlp_sig_index #(
    parameter int ACC_W  = 32,
    parameter int SHIFT  = 12,
    parameter int SIG_AW = 8
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [SIG_AW-1:0]       idx
);

    localparam int AW1 = ACC_W + 1;
    localparam int OFF = 1 << (SIG_AW - 1);
    localparam logic signed [AW1-1:0] HALF   = AW1'(64'sd1 <<< (SHIFT - 1));
    localparam logic signed [AW1-1:0] OFF_W  = AW1'(OFF);
    localparam logic signed [AW1-1:0] LO_LIM = AW1'(-OFF);
    localparam logic signed [AW1-1:0] HI_LIM = AW1'(OFF - 1);

    logic signed [AW1-1:0] widened;
    logic signed [AW1-1:0] biased;
    logic signed [AW1-1:0] scaled;
    logic signed [AW1-1:0] moved;

    always_comb begin
        widened = AW1'(acc);
        biased  = widened + HALF;
        scaled  = biased >>> SHIFT;
        moved   = scaled + OFF_W;
        if (scaled < LO_LIM)
            idx = '0;
        else if (scaled > HI_LIM)
            idx = '1;
        else
            idx = moved[SIG_AW-1:0];
    end

endmodule

// File: rtl/mlp_forward_engine.sv
module mlp_forward_engine
    import mlp_fwd_pkg::*;
#(
    parameter int         NUM_LAYERS  = 3,
    parameter layer_vec_t LAYER_SIZES = 64'h020302,
    parameter int         ACT_W       = 9,
    parameter int         WT_W        = 12,
    parameter int         FRAC        = 8,
    parameter int         ACC_W       = 32,
    parameter int         SIG_AW      = 8,
    parameter int         IDX_FRAC    = 4,
    localparam int        TOTAL       = base_of(LAYER_SIZES, NUM_LAYERS),
    localparam int        RAM_AW      = clog2_min1(TOTAL),
    localparam int        ROM_AW      = clog2_min1(rom_words(LAYER_SIZES, NUM_LAYERS))
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic                    done,
    output logic [ROM_AW-1:0]       wb_addr,
    input  logic signed [WT_W-1:0]  wb_rdata,
    output logic [RAM_AW-1:0]       act_addr,
    output logic                    act_we,
    output logic [ACT_W-1:0]        act_wdata,
    input  logic [ACT_W-1:0]        act_rdata,
    output logic [SIG_AW-1:0]       sig_addr,
    input  logic [ACT_W-1:0]        sig_rdata
);

    localparam int LYR_W = clog2_min1(NUM_LAYERS);
    localparam int SHIFT = 2 * FRAC - IDX_FRAC;
    localparam int IN_N  = size_of(LAYER_SIZES, 0);

    typedef struct packed {
        phase_t                  phase;
        logic [LYR_W-1:0]        layer;
        logic [SZ_W-1:0]         nrn;
        logic [SZ_W-1:0]         k;
        logic [ROM_AW-1:0]       ptr;
        logic                    mac_vld;
        logic signed [ACC_W-1:0] acc;
        logic                    done;
    } regs_t;

    regs_t r_q, r_d;

    logic [SZ_W-1:0]         cur_size, prev_size;
    logic [RAM_AW-1:0]       cur_base, prev_base;
    logic                    is_last;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] bias_al;
    logic [SIG_AW-1:0]       idx;

    mlp_layer_map #(
        .NUM_LAYERS  (NUM_LAYERS),
        .LAYER_SIZES (LAYER_SIZES),
        .LYR_W       (LYR_W),
        .RAM_AW      (RAM_AW)
    ) u_map (
        .layer_idx (r_q.layer),
        .cur_size  (cur_size),
        .prev_size (prev_size),
        .cur_base  (cur_base),
        .prev_base (prev_base),
        .is_last   (is_last)
    );

    mlp_mac_unit #(
        .ACT_W (ACT_W),
        .WT_W  (WT_W),
        .ACC_W (ACC_W)
    ) u_mac (
        .act  (act_rdata),
        .wt   (wb_rdata),
        .prod (prod)
    );

    mlp_sig_index #(
        .ACC_W  (ACC_W),
        .SHIFT  (SHIFT),
        .SIG_AW (SIG_AW)
    ) u_idx (
        .acc (r_q.acc),
        .idx (idx)
    );

    assign bias_al = ACC_W'(wb_rdata) <<< FRAC;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.mac_vld = 1'b0;

        // product of the read issued one clock earlier
        if (r_q.mac_vld)
            r_d.acc = r_q.acc + prod;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.phase = PH_MAC;
                    r_d.layer = LYR_W'(1);
                    r_d.nrn   = '0;
                    r_d.k     = '0;
                    r_d.ptr   = '0;
                    r_d.acc   = '0;
                end
            end
            PH_MAC: begin
                r_d.mac_vld = 1'b1;
                r_d.k       = r_q.k + SZ_W'(1);
                r_d.ptr     = r_q.ptr + ROM_AW'(1);
                if (r_q.k == prev_size - SZ_W'(1)) begin
                    r_d.k     = '0;
                    r_d.phase = PH_BIAS;
                end
            end
            PH_BIAS: begin
                r_d.ptr   = r_q.ptr + ROM_AW'(1);
                r_d.phase = PH_ADD;
            end
            PH_ADD: begin
                r_d.acc   = r_q.acc + bias_al;
                r_d.phase = PH_LUT;
            end
            PH_LUT: begin
                r_d.phase = PH_WR;
            end
            PH_WR: begin
                r_d.acc = '0;
                if (r_q.nrn == cur_size - SZ_W'(1)) begin
                    r_d.nrn = '0;
                    if (is_last) begin
                        r_d.phase = PH_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.layer = r_q.layer + LYR_W'(1);
                        r_d.phase = PH_MAC;
                    end
                end else begin
                    r_d.nrn   = r_q.nrn + SZ_W'(1);
                    r_d.phase = PH_MAC;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.phase   <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        wb_addr   = r_q.ptr;
        act_we    = (r_q.phase == PH_WR);
        act_addr  = act_we ? (cur_base + RAM_AW'(r_q.nrn))
                           : (prev_base + RAM_AW'(r_q.k));
        act_wdata = sig_rdata;
        sig_addr  = idx;
        done      = r_q.done;
    end

endmodule

// File: rtl/mlp_forward_engine_chk.sv
module mlp_forward_engine_chk #(
    parameter int RAM_AW = 3,
    parameter int IN_N   = 2,
    parameter int TOTAL  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              act_we,
    input logic [RAM_AW-1:0] act_addr
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                   // R9

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(act_we));                           // R9

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !act_we);                                 // R9

    AST_NO_INPUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        act_we |-> int'(act_addr) >= IN_N);                // R2

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_we |-> int'(act_addr) < TOTAL);                // R3

    AST_WRITE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        act_we |=> !act_we);                               // R8

endmodule

bind mlp_forward_engine mlp_forward_engine_chk #(
    .RAM_AW (RAM_AW),
    .IN_N   (IN_N),
    .TOTAL  (TOTAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .act_we   (act_we),
    .act_addr (act_addr)
);

// File: tb/mlp_forward_engine_test.sv
module mlp_forward_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int SZ   [NL]  = '{2, 3, 2};
    localparam int BASE [NL]  = '{0, 2, 5};
    localparam int MAXC       = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic              done;
    logic [4:0]        wb_addr;
    logic signed [11:0] wb_rdata;
    logic [2:0]        act_addr;
    logic              act_we;
    logic [8:0]        act_wdata;
    logic [8:0]        act_rdata;
    logic [7:0]        sig_addr;
    logic [8:0]        sig_rdata;

    int rom [0:31];
    int ram [0:7];
    int tbl [0:255];
    int ev  [0:7];
    int wr_cyc [0:7];
    int wr_adr [0:7];
    int wr_dat [0:7];
    int exp_wb [0:MAXC-1];
    int exp_ra [0:MAXC-1];
    int nwr;
    int total;
    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlp_forward_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .done      (done),
        .wb_addr   (wb_addr),
        .wb_rdata  (wb_rdata),
        .act_addr  (act_addr),
        .act_we    (act_we),
        .act_wdata (act_wdata),
        .act_rdata (act_rdata),
        .sig_addr  (sig_addr),
        .sig_rdata (sig_rdata)
    );

    // memories seen at the ports, one clock read latency
    always @(posedge clk) begin
        wb_rdata  <= 12'(rom[wb_addr]);
        act_rdata <= 9'(ram[act_addr]);
        sig_rdata <= 9'(tbl[sig_addr]);
        if (act_we) ram[act_addr] <= int'(act_wdata);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic next_w(output int w, input int span);
        seed = seed * 32'd1664525 + 32'd1013904223;
        w = int'((seed >> 8) % (2 * span)) - span;
    endtask

    function automatic int rom_ix(int l, int n);
        int p = 0;
        for (int j = 1; j < l; j++) p += SZ[j] * (SZ[j-1] + 1);
        return p + n * (SZ[l-1] + 1);
    endfunction

    task automatic sigmoid_table();
        for (int i = 0; i < 256; i++) begin
            real x;
            x = (i - 128) / 16.0;
            tbl[i] = $rtoi(256.0 / (1.0 + $exp(-x)) + 0.5);
        end
    endtask

    task automatic ramp_table();
        for (int i = 0; i < 256; i++) tbl[i] = i;
    endtask

    task automatic random_rom(input int span);
        for (int i = 0; i < 32; i++) begin
            int w;
            next_w(w, span);
            rom[i] = w;
        end
    endtask

    task automatic build_expect();
        int cum = 0;
        nwr = 0;
        for (int c = 0; c < MAXC; c++) begin
            exp_wb[c] = -1;
            exp_ra[c] = -1;
        end
        for (int l = 1; l < NL; l++) begin
            for (int n = 0; n < SZ[l]; n++) begin
                longint acc = 0;
                int idx;
                for (int k = 0; k < SZ[l-1]; k++) begin
                    acc += longint'(ev[BASE[l-1] + k]) * longint'(rom[rom_ix(l, n) + k]);
                    exp_wb[cum + k] = rom_ix(l, n) + k;
                    exp_ra[cum + k] = BASE[l-1] + k;
                end
                exp_wb[cum + SZ[l-1]] = rom_ix(l, n) + SZ[l-1];
                acc += longint'(rom[rom_ix(l, n) + SZ[l-1]]) * 256;
                idx = int'((acc + 2048) >>> 12) + 128;
                if (idx < 0)   idx = 0;
                if (idx > 255) idx = 255;
                ev[BASE[l] + n] = tbl[idx];
                wr_cyc[nwr] = cum + SZ[l-1] + 3;
                wr_adr[nwr] = BASE[l] + n;
                wr_dat[nwr] = tbl[idx];
                nwr++;
                cum += SZ[l-1] + 4;
            end
        end
        total = cum;
    endtask

    task automatic run(input int in0, input int in1, input int xs_a, input int xs_b);
        int n_done = 0;
        ram[0] = in0;
        ram[1] = in1;
        ev[0]  = in0;
        ev[1]  = in1;
        build_expect();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c <= total + 8; c++) begin
            int hit = -1;
            for (int i = 0; i < nwr; i++) if (wr_cyc[i] == c) hit = i;
            chk(act_we == (hit >= 0), "R8", "write strobe timing", int'(act_we), int'(hit >= 0));
            if (hit >= 0 && act_we) begin
                chk(int'(act_addr) == wr_adr[hit], "R3", "write address", int'(act_addr), wr_adr[hit]);
                chk(int'(act_wdata) == wr_dat[hit], "R4", "written activation", int'(act_wdata), wr_dat[hit]);
            end
            if (c < MAXC && exp_wb[c] >= 0)
                chk(int'(wb_addr) == exp_wb[c], "R5", "weight store address", int'(wb_addr), exp_wb[c]);
            if (c < MAXC && exp_ra[c] >= 0)
                chk(int'(act_addr) == exp_ra[c], "R3", "activation read address", int'(act_addr), exp_ra[c]);
            chk(done == (c == total), "R9", "done timing", int'(done), int'(c == total));
            if (done) n_done++;
            start = (c == xs_a || c == xs_b);
            @(negedge clk);
        end
        start = 1'b0;
        chk(n_done == 1, "R10", "done pulses per run", n_done, 1);
        chk(ram[0] == in0, "R2", "input word 0 kept", ram[0], in0);
        chk(ram[1] == in1, "R2", "input word 1 kept", ram[1], in1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rom[i] = 0;
        for (int i = 0; i < 8; i++)  ram[i] = 0;
        sigmoid_table();
        rst_n = 1'b0;
        start = 1'b0;

        // R1: reset and idle state
        repeat (3) begin
            @(negedge clk);
            chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
            chk(act_we == 1'b0, "R1", "write in reset", int'(act_we), 0);
        end
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(done == 1'b0, "R1", "done while idle", int'(done), 0);
            chk(act_we == 1'b0, "R1", "write while idle", int'(act_we), 0);
        end

        // sigmoid table, random weights, two input patterns
        random_rom(512);
        run(256, 128, -1, -1);
        random_rom(900);
        run(0, 37, -1, -1);

        // R7: saturation at both table ends (ramp table shows the index)
        ramp_table();
        for (int n = 0; n < 3; n++)
            for (int k = 0; k < 3; k++) rom[rom_ix(1, n) + k] = 2047;
        for (int n = 0; n < 2; n++)
            for (int k = 0; k < 4; k++) rom[rom_ix(2, n) + k] = -2048;
        run(256, 256, -1, -1);
        for (int a = 2; a < 5; a++) chk(ram[a] == 255, "R7", "upper clamp", ram[a], 255);
        for (int a = 5; a < 7; a++) chk(ram[a] == 0, "R7", "lower clamp", ram[a], 0);

        // R6: rounding on exact half steps
        for (int i = 0; i < 32; i++) rom[i] = 0;
        rom[rom_ix(1, 0)] = 8;
        rom[rom_ix(1, 1)] = -8;
        rom[rom_ix(1, 2)] = 7;
        run(256, 0, -1, -1);
        chk(ram[2] == 129, "R6", "tie +2048 rounds up", ram[2], 129);
        chk(ram[3] == 128, "R6", "tie -2048 rounds up", ram[3], 128);
        chk(ram[4] == 128, "R6", "below half rounds down", ram[4], 128);
        chk(ram[5] == 128, "R6", "zero sum centre", ram[5], 128);

        // R10: start pulses during a run are ignored
        sigmoid_table();
        random_rom(700);
        run(200, 90, 2, 31);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule